// File: doc/BRIEF.md
# AHB-Lite to Register-Interface Bridge

This block sits on an AHB-Lite bus as a subordinate and converts each accepted transfer into a request on a simple register-access port. The request carries a valid strobe, a write flag, an address, write data and byte-lane strobes. The register side answers with an acknowledge, read data and an error flag. Each accepted transfer raises the register request in its data phase. If the register side acknowledges in that same cycle, the transfer finishes with no wait state. A fresh address phase can then be accepted on every clock, so a register file reaches full bus throughput.

Slow registers simply hold off their acknowledge. The bridge stretches the data phase by pulling its ready output low, and it keeps the request steady until the acknowledge arrives. A register-side error becomes the two-cycle AHB ERROR response. The burst-type input is read by nothing: every beat is decoded from its own address, so a burst looks the same as back-to-back single transfers. IDLE and BUSY cycles start nothing on the register side.

Top module: `ahbl_reg_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it with no transfer, `hreadyout` is 1, `hresp` is 0 (OKAY) and `req_vld` is 0.
- R2: A transfer is accepted on a clock edge where `hready`, `hsel` and `htrans[1]` are all 1 (`htrans` 2'b10 NONSEQ or 2'b11 SEQ). In the next cycle `req_vld` is 1, `req_addr` equals the accepted `haddr` and `req_wr` equals the accepted `hwrite`.
- R3: During the data phase of a write, `req_wdata` equals the `hwdata` the bus presents in that cycle.
- R4: `req_strb` bit i enables byte lane `req_wdata[8i+7:8i]`. For `hsize` 0 (byte) only lane `haddr[1:0]` is set. For `hsize` 1 (halfword) lanes 1:0 are set, or lanes 3:2 when `haddr[1]` is 1. For `hsize` 2 (word) all four lanes are set.
- R5: When `rsp_ack` is 1 and `rsp_err` is 0 in the same cycle as `req_vld`, `hreadyout` is 1 and `hresp` is 0 in that cycle, and `hrdata` equals `rsp_rdata`. Accepted transfers may follow one another on every cycle.
- R6: While `req_vld` is 1 and `rsp_ack` is 0, `hreadyout` is 0 and `hresp` is 0. The request (`req_vld`, `req_addr`, `req_wr`, `req_strb`) stays unchanged in the next cycle.
- R7: When `rsp_ack` and `rsp_err` are both 1 with `req_vld`, that cycle shows `hreadyout`=0 and `hresp`=1. The next cycle shows `hreadyout`=1 and `hresp`=1, with `req_vld` 0.
- R8: When `htrans` is IDLE (2'b00) or BUSY (2'b01), or `hsel` is 0, no request follows, and the next cycle answers with `hreadyout`=1 and `hresp`=0.
- R9: `hburst` has no effect. SEQ beats inside a burst are handled exactly as NONSEQ beats at the same address.
- R10: While `hready` is 0, no new address phase is accepted. A transfer held on the bus during a stall is accepted only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (log2 bytes) |
| hburst | input | 3 | Burst type, ignored |
| hwdata | input | DW | Write data, valid in data phase |
| hready | input | 1 | Bus-wide ready, 1 = previous data phase ends this cycle |
| hreadyout | output | 1 | Ready driven by this subordinate |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DW | Read data |
| req_vld | output | 1 | Register access request |
| req_wr | output | 1 | Request is a write |
| req_addr | output | AW | Register address |
| req_wdata | output | DW | Register write data |
| req_strb | output | DW/8 | Byte-lane enables |
| rsp_ack | input | 1 | Register side completes the request |
| rsp_err | input | 1 | Register side reports an error, qualified by rsp_ack |
| rsp_rdata | input | DW | Register read data, qualified by rsp_ack |

## Verification
The hardest case to reach from the ports is a wait-stated or erroring data phase that overlaps a live address phase. The overlap must not re-sample or lose the pending transfer, and it must not send a request during the error response's second cycle. The bench runs a pipelined master model whose address phase always runs one beat ahead. Its register responder picks a random acknowledge delay and faults one address window. This places stalls, errors, BUSY beats and deselected cycles next to each other in many combinations. A directed prologue first forces zero-wait back-to-back traffic, every byte lane, a delayed read, a BUSY gap inside a burst and an error followed at once by a new transfer.

// File: rtl/ahbl_bridge_pkg.sv
// Package: shared encodings for the AHB-Lite register bridge.
// Assumes: AHB-Lite transfer-type and response encodings.
package ahbl_bridge_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/ahbl_strobe_gen.sv
// Module: ahbl_strobe_gen
// Derives byte-lane enables from the transfer size and the low address bits.
// Assumes: naturally aligned transfers; a size wider than the bus is clipped
// to the bus width; DW is at least 16.
module ahbl_strobe_gen #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LB = $clog2(NB)
) (
    input  logic [LB-1:0] addr_lo,
    input  logic [2:0]    size,
    output logic [NB-1:0] strb
);
    logic [2:0] size_c;
    int         span;
    int         base;

    // Clip the size to the bus width and locate the aligned byte window.
    always_comb begin
        size_c = (size > 3'(LB)) ? 3'(LB) : size;
        span   = 1 << size_c;
        base   = int'(addr_lo) & ~(span - 1);
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign strb[g] = (g >= base) && (g < base + span);
    end
endmodule

// File: rtl/ahbl_addr_stage.sv
// Module: ahbl_addr_stage
// Captures the address-phase controls of an accepted transfer. They are
// presented to the register side during that transfer's data phase.
// Assumes: take is asserted only while bus ready is high, so the captured
// values stay put across wait states.
module ahbl_addr_stage #(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LB = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] haddr,
    input  logic          hwrite,
    input  logic [2:0]    hsize,
    output logic [AW-1:0] addr_q,
    output logic          wr_q,
    output logic [NB-1:0] strb_q
);
    logic [NB-1:0] strb_live;

    ahbl_strobe_gen #(.DW(DW)) strobe_i (
        .addr_lo (haddr[LB-1:0]),
        .size    (hsize),
        .strb    (strb_live)
    );

    // Register the address, direction and lane enables at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
            strb_q <= '0;
        end else if (take) begin
            addr_q <= haddr;
            wr_q   <= hwrite;
            strb_q <= strb_live;
        end
    end
endmodule

// File: rtl/ahbl_phase_ctrl.sv
// Module: ahbl_phase_ctrl
// Tracks the data phase and produces the request strobe, the ready output
// and the response, including wait states and the two-cycle error.
// Assumes: hready is the bus-wide ready, and it is low whenever this
// block drives hreadyout low.
module ahbl_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic take,
    input  logic rsp_ack,
    input  logic rsp_err,
    output logic req_vld,
    output logic hreadyout,
    output logic hresp
);
    import ahbl_bridge_pkg::*;

    logic dp_q;   // a data phase belongs to this subordinate
    logic err_q;  // second cycle of an ERROR response
    logic fail_now;

    assign req_vld  = dp_q && !err_q;
    assign fail_now = req_vld && rsp_ack && rsp_err;

    // Open a data phase when the bus moves on; hold it through wait states.
    always_ff @(posedge clk) begin
        if (!rst_n)      dp_q <= 1'b0;
        else if (hready) dp_q <= take;
    end

    // Mark the second cycle of an error response.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= fail_now;
    end

    // Ready: high when idle, on a clean acknowledge, or to end an error.
    always_comb begin
        if (err_q)     hreadyout = 1'b1;
        else if (dp_q) hreadyout = rsp_ack && !rsp_err;
        else           hreadyout = 1'b1;
        hresp = (err_q || fail_now) ? RESP_ERROR : RESP_OKAY;
    end
endmodule

// File: rtl/ahbl_reg_bridge.sv
// Module: ahbl_reg_bridge (top)
// AHB-Lite subordinate to register-interface bridge. Zero-wait pipelined
// transfers when the register side acknowledges at once, wait states
// otherwise, and a two-cycle ERROR on a register-side fault.
// Assumes: burst type is ignored; each beat uses its own address.
module ahbl_reg_bridge #(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [2:0]    hsize,
    input  logic [2:0]    hburst,
    input  logic [DW-1:0] hwdata,
    input  logic          hready,
    output logic          hreadyout,
    output logic          hresp,
    output logic [DW-1:0] hrdata,
    output logic          req_vld,
    output logic          req_wr,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic [NB-1:0] req_strb,
    input  logic          rsp_ack,
    input  logic          rsp_err,
    input  logic [DW-1:0] rsp_rdata
);
    logic take;
    logic unused_bits;

    // Accept NONSEQ/SEQ when selected and the bus is ready; BUSY/IDLE are not.
    assign take        = hready && hsel && htrans[1];
    assign unused_bits = ^{hburst, htrans[0]};

    ahbl_addr_stage #(.AW(AW), .DW(DW)) addr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .haddr  (haddr),
        .hwrite (hwrite),
        .hsize  (hsize),
        .addr_q (req_addr),
        .wr_q   (req_wr),
        .strb_q (req_strb)
    );

    ahbl_phase_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .take      (take),
        .rsp_ack   (rsp_ack),
        .rsp_err   (rsp_err),
        .req_vld   (req_vld),
        .hreadyout (hreadyout),
        .hresp     (hresp)
    );

    // Data-phase pass-through: write data in, read data out.
    assign req_wdata = hwdata;
    assign hrdata    = rsp_rdata;
endmodule

// File: rtl/ahbl_reg_bridge_chk.sv
// Module: ahbl_reg_bridge_chk
// Protocol checker bound to the bridge top; observes ports only.
// Assumes: rsp_ack is only given while req_vld is high.
module ahbl_reg_bridge_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsel,
    input logic [1:0]    htrans,
    input logic          hready,
    input logic          hreadyout,
    input logic          hresp,
    input logic          req_vld,
    input logic          req_wr,
    input logic [AW-1:0] req_addr,
    input logic [NB-1:0] req_strb,
    input logic          rsp_ack,
    input logic          rsp_err
);
    // R2
    req_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hready && hsel && htrans[1] |=> req_vld);

    // R4
    strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> req_strb != '0);

    // R5
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && rsp_ack && !rsp_err |-> hreadyout && !hresp);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !rsp_ack && !hready |=> req_vld && $stable(req_addr)
                                        && $stable(req_wr) && $stable(req_strb));

    // R6
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !rsp_ack |-> !hreadyout && !hresp);

    // R7
    err_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && rsp_ack && rsp_err |-> !hreadyout && hresp);

    // R7
    err_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && rsp_ack && rsp_err |=> hreadyout && hresp && !req_vld);

    // R8
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hready && !hresp && !(hsel && htrans[1]) |=> !req_vld && hreadyout && !hresp);
endmodule

bind ahbl_reg_bridge ahbl_reg_bridge_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsel      (hsel),
    .htrans    (htrans),
    .hready    (hready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .req_vld   (req_vld),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_strb  (req_strb),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err)
);

// File: tb/ahbl_reg_bridge_tb_top.sv
`timescale 1ns/1ps
// Bench: pipelined AHB-Lite master model plus a register responder with
// random acknowledge delay; expected values come from bench functions.
module ahbl_reg_bridge_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int SLOTS = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic [2:0]    hsize = 3'd0;
    logic [2:0]    hburst = 3'd0;
    logic [DW-1:0] hwdata = '0;
    logic          hready;
    logic          hreadyout;
    logic          hresp;
    logic [DW-1:0] hrdata;
    logic          req_vld;
    logic          req_wr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [NB-1:0] req_strb;
    logic          rsp_ack = 1'b0;
    logic          rsp_err = 1'b0;
    logic [DW-1:0] rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    assign hready = hreadyout;
    always #10 clk = ~clk;

    ahbl_reg_bridge #(.AW(AW), .DW(DW)) dut_i (.*);

    // Bench model state: address-phase beat (ap_*) and data-phase beat (dp_*).
    bit            ap_v, dp_v;
    logic [AW-1:0] ap_a, dp_a;
    logic          ap_w, dp_w;
    logic [2:0]    ap_s, dp_s;
    logic [DW-1:0] ap_d, dp_d;
    int            ap_slot, dp_slot;
    int            wait_left;
    bit            err2, err_next, last_rdy;
    logic [DW-1:0] mem [16];

    function automatic logic [NB-1:0] exp_strb(logic [AW-1:0] a, logic [2:0] s);
        case (s)
            3'd0:    return 4'b0001 << a[1:0];
            3'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic bit is_err_addr(logic [AW-1:0] a);
        return a[11:8] == 4'hF;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Put one beat on the bus; directed for early slots, random after.
    task automatic drive_ap(int slot);
        logic [1:0] t;
        logic [2:0] s;
        logic [AW-1:0] a;
        logic w, sel;
        sel = 1'b1;
        hburst = 3'($urandom_range(0, 7));
        case (slot)
            0:  begin t = 2'b10; w = 1; s = 2; a = 16'h0004; end
            1:  begin t = 2'b11; w = 0; s = 2; a = 16'h0004; end
            2:  begin t = 2'b10; w = 1; s = 0; a = 16'h0009; end
            3:  begin t = 2'b10; w = 1; s = 0; a = 16'h000B; end
            4:  begin t = 2'b10; w = 1; s = 1; a = 16'h000E; end
            5:  begin t = 2'b10; w = 0; s = 2; a = 16'h0008; end
            6:  begin t = 2'b01; w = 0; s = 2; a = 16'h000C; hburst = 3'd1; end
            7:  begin t = 2'b11; w = 0; s = 2; a = 16'h000C; hburst = 3'd1; end
            8:  begin t = 2'b10; w = 1; s = 2; a = 16'h0F00; end
            9:  begin t = 2'b10; w = 0; s = 2; a = 16'h0004; end
            10: begin t = 2'b00; w = 0; s = 0; a = 16'h0000; end
            11: begin t = 2'b10; w = 1; s = 2; a = 16'h0010; sel = 0; end
            default: begin
                t = 2'($urandom_range(0, 3));
                w = 1'($urandom_range(0, 1));
                s = 3'($urandom_range(0, 2));
                a = 16'($urandom_range(0, 63));
                if ($urandom_range(0, 15) == 0) a[11:8] = 4'hF;
                a = a & ~((16'd1 << s) - 16'd1);
                sel = ($urandom_range(0, 7) != 0);
            end
        endcase
        hsel = sel; htrans = t; hwrite = w; hsize = s; haddr = a;
        ap_v = sel && t[1]; ap_a = a; ap_w = w; ap_s = s;
        ap_d = $urandom; ap_slot = slot;
    endtask

    initial begin
        int slot;
        void'($urandom(32'd1234));
        foreach (mem[i]) mem[i] = '0;
        ap_v = 0; dp_v = 0; err2 = 0; err_next = 0; last_rdy = 1; slot = 0; wait_left = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(hreadyout === 1'b1, "R1", "hreadyout in reset", 32'(hreadyout), 1);
        chk(hresp === 1'b0, "R1", "hresp in reset", 32'(hresp), 0);
        chk(req_vld === 1'b0, "R1", "req_vld in reset", 32'(req_vld), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 first cycle after reset, bus idle
        chk(hreadyout === 1'b1 && hresp === 1'b0 && req_vld === 1'b0, "R1", "idle after reset",
            {29'd0, hreadyout, hresp, req_vld}, 32'h4);
        for (int cyc = 0; cyc < SLOTS; cyc++) begin
            @(posedge clk); #1;
            err2 = err_next; err_next = 0;
            if (last_rdy) begin
                dp_v = ap_v; dp_a = ap_a; dp_w = ap_w; dp_s = ap_s; dp_d = ap_d; dp_slot = ap_slot;
                hwdata = dp_w ? dp_d : DW'($urandom);
                if (dp_v) begin
                    if (dp_slot < 12) wait_left = (dp_slot == 5) ? 2 : 0;
                    else wait_left = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0;
                end
                drive_ap(slot); slot++;
            end
            @(negedge clk);
            // Register responder
            rsp_ack = 0; rsp_err = 0; rsp_rdata = DW'($urandom);
            if (dp_v && !err2) begin
                if (wait_left == 0) begin
                    rsp_ack = 1;
                    rsp_err = is_err_addr(dp_a);
                    if (!dp_w && !rsp_err) rsp_rdata = mem[dp_a[5:2]];
                end else wait_left--;
            end
            #1;
            if (dp_v && !err2) begin
                // R2 R9 request mirrors the accepted beat (SEQ/NONSEQ alike)
                chk(req_vld === 1'b1, "R2", "req_vld", 32'(req_vld), 1);
                chk(req_addr === dp_a && req_wr === dp_w, "R2", "req_addr/req_wr",
                    {15'd0, req_wr, req_addr}, {15'd0, dp_w, dp_a});
                // R4 lane enables
                chk(req_strb === exp_strb(dp_a, dp_s), "R4", "req_strb",
                    32'(req_strb), 32'(exp_strb(dp_a, dp_s)));
                // R3 write data
                if (dp_w) chk(req_wdata === dp_d, "R3", "req_wdata", req_wdata, dp_d);
                if (rsp_ack && rsp_err) begin
                    // R7 first error cycle
                    chk(hreadyout === 1'b0 && hresp === 1'b1, "R7", "error cycle 1",
                        {30'd0, hreadyout, hresp}, 32'h1);
                    last_rdy = 0; err_next = 1;
                end else if (rsp_ack) begin
                    // R5 zero-wait completion
                    chk(hreadyout === 1'b1 && hresp === 1'b0, "R5", "ready on ack",
                        {30'd0, hreadyout, hresp}, 32'h2);
                    if (!dp_w) chk(hrdata === rsp_rdata, "R5", "hrdata", hrdata, rsp_rdata);
                    else
                        for (int b = 0; b < NB; b++)
                            if (exp_strb(dp_a, dp_s)[b]) mem[dp_a[5:2]][8*b +: 8] = dp_d[8*b +: 8];
                    last_rdy = 1;
                end else begin
                    // R6 R10 wait state
                    chk(hreadyout === 1'b0 && hresp === 1'b0, "R6", "wait state",
                        {30'd0, hreadyout, hresp}, 32'h0);
                    last_rdy = 0;
                end
            end else if (err2) begin
                // R7 second error cycle
                chk(hreadyout === 1'b1 && hresp === 1'b1 && req_vld === 1'b0, "R7", "error cycle 2",
                    {29'd0, hreadyout, hresp, req_vld}, 32'h6);
                last_rdy = 1;
            end else begin
                // R8 IDLE/BUSY/deselected: no request, OKAY
                chk(hreadyout === 1'b1 && hresp === 1'b0 && req_vld === 1'b0, "R8", "no transfer",
                    {29'd0, hreadyout, hresp, req_vld}, 32'h4);
                last_rdy = 1;
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * (SLOTS + 1000));
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule